// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches for software that has stopped making progress. A 12-bit counter counts down on a low-speed tick. The tick first passes through a prescaler whose divide ratio is a power of two from 1 to 128. Software must service the counter before it runs out. If the counter underflows, the block raises an underflow flag and, when resets are enabled, drives an active-low reset request for a fixed number of system clock cycles.

Servicing is windowed. A service write must carry a 16-bit key. It is accepted only while the count is at or below a programmable window limit (the delta value). A keyed service that arrives while the count is still above the limit is treated as a fault: the block sets an error flag and requests a reset. Writes with any other key do nothing.

Configuration goes through a small word-addressed register bus. A lock register can freeze the timing-related settings. Counting can be paused independently during a debug halt and during sleep, and it stops entirely while the block is disabled.

Top module: `wwdt_core`

## Requirements
- R1: After reset, CTRL (addr 0) reads 0x0003, which means enabled (bit 0), reset request enabled (bit 1), both stop bits clear (bits 2 and 3) and prescale select 0 (bits 6:4). RELOAD (addr 1), DELTA (addr 2) and COUNT (addr 6) read 0xFFF, STATUS (addr 4) reads 0, LOCK (addr 5) reads 0, and the reset output is high.
- R2: With prescale select s, the counter decrements once per 2^s qualifying ticks. The count in the prescaler starts from zero after each accepted service.
- R3: A decrement step taken while the count is 0 is an underflow. It sets STATUS bit 0 and reloads the counter with RELOAD.
- R4: On an underflow or a service fault with CTRL bit 1 set, the reset output goes low for exactly 4 clock cycles. With CTRL bit 1 clear, it stays high.
- R5: Writing the key 0xC3A5 to KICK (addr 3) while COUNT <= DELTA copies RELOAD into the counter. Writing it while COUNT > DELTA sets STATUS bit 1 and leaves the counter unchanged.
- R6: A KICK write with any other value changes neither the counter nor the flags, and causes no reset.
- R7: Reading STATUS clears both flags.
- R8: Writing 0x6E5A to LOCK unlocks the block, and writing any other value locks it. LOCK bit 0 reads 1 when locked. While locked, writes to RELOAD, DELTA, CTRL bit 1 and CTRL bits 6:4 are ignored, but CTRL bits 0, 2 and 3 still take the written value.
- R9: Counting pauses while CTRL bit 2 is set and the debug-halt input is high. It also pauses while CTRL bit 3 is set and the sleep input is high, and whenever CTRL bit 0 is clear. With a stop bit clear, the matching input has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per low-speed clock period |
| dbg_halt_i | input | 1 | Processor halted in debug |
| sleep_i | input | 1 | Processor in sleep or deep sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears STATUS when addressed) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| wdt_rst_n_o | output | 1 | Active-low reset request |

## Verification
The assertions check several rules on every cycle:
- the counter only ever holds, steps down by one, or loads the reload value;
- an underflow always raises its flag;
- an early keyed service always raises the error flag without moving the counter;
- a debug halt with its stop bit set freezes the count;
- the lock freezes the reload and window values;
- a falling reset output stays low for its full length, and no pulse starts while resets are disabled.

Other behaviours can only be shown by the bench's scenarios. These are the exact prescale ratio, the boundary of the window (count equal to the delta value against one above it), the flags being cleared by a read, the split of lockable and free CTRL bits, and the sleep and disable pauses.

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int CNT_W      = 12,
  parameter int PSEL_W     = 3,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int KEY_W      = 16,
  parameter logic [KEY_W-1:0] KICK_KEY   = 16'hC3A5,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h6E5A,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dbg_halt_i,
  input  logic              sleep_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_n_o
);

  localparam int PRE_W = (1 << PSEL_W) - 1;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DELTA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(6);

  logic              en_q, rsten_q, sdbg_q, sslp_q, lock_q, uf_q, err_q;
  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  reload_q, delta_q, cnt_q;
  logic [PRE_W-1:0]  pre_q, div_m1;
  logic [PRE_W:0]    div_full;
  logic [RC_W-1:0]   rc_q;
  logic              unused_bits;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_rld   = bus_wr && bus_addr == A_RLD   && !lock_q;
  wire wr_delta = bus_wr && bus_addr == A_DELTA && !lock_q;
  wire wr_lock  = bus_wr && bus_addr == A_LOCK;
  wire rd_stat  = bus_rd && bus_addr == A_STAT;
  wire kick_hit = bus_wr && bus_addr == A_KICK && bus_wdata[KEY_W-1:0] == KICK_KEY;
  wire in_win   = cnt_q <= delta_q;
  wire kick_ok  = kick_hit && in_win;
  wire kick_bad = kick_hit && !in_win;
  wire run      = en_q && !(dbg_halt_i && sdbg_q) && !(sleep_i && sslp_q);
  wire adv      = run && tick_i && !kick_hit;

  assign div_full = (PRE_W+1)'(1) << psel_q;
  assign div_m1   = PRE_W'(div_full - 1'b1);

  wire pre_last = pre_q >= div_m1;
  wire step     = adv && pre_last;
  wire uf_evt   = step && cnt_q == '0;
  wire trip     = (uf_evt || kick_bad) && rsten_q;

  assign unused_bits = ^bus_wdata;
  assign wdt_rst_n_o = rc_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b1;
      rsten_q  <= 1'b1;
      sdbg_q   <= 1'b0;
      sslp_q   <= 1'b0;
      psel_q   <= '0;
      reload_q <= '1;
      delta_q  <= '1;
      lock_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[0];
        sdbg_q <= bus_wdata[2];
        sslp_q <= bus_wdata[3];
        if (!lock_q) begin
          rsten_q <= bus_wdata[1];
          psel_q  <= bus_wdata[4 +: PSEL_W];
        end
      end
      if (wr_rld)   reload_q <= bus_wdata[CNT_W-1:0];
      if (wr_delta) delta_q  <= bus_wdata[CNT_W-1:0];
      if (wr_lock)  lock_q   <= bus_wdata[KEY_W-1:0] != UNLOCK_KEY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      pre_q <= '0;
    end else begin
      if (kick_ok)   pre_q <= '0;
      else if (adv)  pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (kick_ok)   cnt_q <= reload_q;
      else if (step) cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
      err_q <= 1'b0;
      rc_q <= '0;
    end else begin
      uf_q  <= uf_evt   || (uf_q  && !rd_stat);
      err_q <= kick_bad || (err_q && !rd_stat);
      if (trip)             rc_q <= RC_W'(RST_CYCLES);
      else if (rc_q != '0)  rc_q <= rc_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'({psel_q, sslp_q, sdbg_q, rsten_q, en_q});
      A_RLD:   bus_rdata = DATA_W'(reload_q);
      A_DELTA: bus_rdata = DATA_W'(delta_q);
      A_STAT:  bus_rdata = DATA_W'({err_q, uf_q});
      A_LOCK:  bus_rdata = DATA_W'(lock_q);
      A_CNT:   bus_rdata = DATA_W'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

module wwdt_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 16,
  parameter int RC_W   = 3,
  parameter logic [KEY_W-1:0] KICK_KEY = 16'hC3A5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_halt_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wdt_rst_n_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  delta_q,
  input logic              lock_q,
  input logic              uf_q,
  input logic              err_q,
  input logic              rsten_q,
  input logic              sdbg_q,
  input logic [RC_W-1:0]   rc_q,
  input logic              uf_evt
);
  wire kick_w  = bus_wr && bus_addr == ADDR_W'(3);
  wire key_hit = kick_w && bus_wdata[KEY_W-1:0] == KICK_KEY;

  AST_CNT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - 1'b1) || (cnt_q == $past(reload_q))); // R2
  AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_q); // R3
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n_o) |-> ##3 !wdt_rst_n_o); // R4
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsten_q && rc_q == '0) |=> wdt_rst_n_o); // R4
  AST_EARLY_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && cnt_q > delta_q) |=> (err_q && $stable(cnt_q))); // R5
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(reload_q) && $stable(delta_q))); // R8
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt_i && sdbg_q && !kick_w) |=> $stable(cnt_q)); // R9
endmodule

bind wwdt_core wwdt_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
  .RC_W(RC_W), .KICK_KEY(KICK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wdt_rst_n_o(wdt_rst_n_o),
  .cnt_q(cnt_q), .reload_q(reload_q), .delta_q(delta_q), .lock_q(lock_q),
  .uf_q(uf_q), .err_q(err_q), .rsten_q(rsten_q), .sdbg_q(sdbg_q),
  .rc_q(rc_q), .uf_evt(uf_evt)
);

// File: tb/sim_wwdt_core.sv
module sim_wwdt_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, dbg_halt_i = 1'b0, sleep_i = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdt_rst_n_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] KEY = 16'hC3A5, UNL = 16'h6E5A;

  always #10 clk = ~clk;

  wwdt_core u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #2 d = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 rst out", int'(wdt_rst_n_o), 1);
    rd_chk("R1 ctrl", 3'd0, 'h0003);
    rd_chk("R1 reload", 3'd1, 'hFFF);
    rd_chk("R1 delta", 3'd2, 'hFFF);
    rd_chk("R1 status", 3'd4, 0);
    rd_chk("R1 lock", 3'd5, 0);
    rd_chk("R1 count", 3'd6, 'hFFF);
  endtask

  task automatic t_prescale;
    wr(3'd1, 16'd10);
    wr(3'd3, KEY);
    rd_chk("R5 valid reload", 3'd6, 10);
    wr(3'd0, 16'h0023);
    wr(3'd3, KEY);
    tick(3);
    rd_chk("R2 div4 3 ticks", 3'd6, 10);
    tick(1);
    rd_chk("R2 div4 4th tick", 3'd6, 9);
    tick(4);
    rd_chk("R2 div4 8 ticks", 3'd6, 8);
    wr(3'd0, 16'h0003);
    tick(2);
    rd_chk("R2 div1", 3'd6, 6);
  endtask

  task automatic t_underflow;
    wr(3'd1, 16'd5);
    wr(3'd3, KEY);
    tick(5);
    rd_chk("R3 at zero", 3'd6, 0);
    chk("R4 high at zero", int'(wdt_rst_n_o), 1);
    tick(1);
    chk("R4 low c1", int'(wdt_rst_n_o), 0);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      chk("R4 low hold", int'(wdt_rst_n_o), 0);
    end
    @(negedge clk);
    chk("R4 release", int'(wdt_rst_n_o), 1);
    rd_chk("R3 reloaded", 3'd6, 5);
    rd_chk("R3 uf flag", 3'd4, 1);
    rd_chk("R7 cleared", 3'd4, 0);
  endtask

  task automatic t_noreset;
    wr(3'd0, 16'h0001);
    wr(3'd3, KEY);
    tick(6);
    chk("R4 no pulse", int'(wdt_rst_n_o), 1);
    idle(3);
    chk("R4 no pulse later", int'(wdt_rst_n_o), 1);
    rd_chk("R3 uf flag noreset", 3'd4, 1);
    rd_chk("R3 count", 3'd6, 5);
    wr(3'd0, 16'h0003);
  endtask

  task automatic t_window;
    wr(3'd1, 16'd10);
    wr(3'd3, KEY);
    wr(3'd2, 16'd3);
    wr(3'd3, KEY);
    chk("R5 early reset", int'(wdt_rst_n_o), 0);
    rd_chk("R5 count kept", 3'd6, 10);
    idle(6);
    tick(6);
    wr(3'd3, KEY);
    chk("R5 delta+1 reset", int'(wdt_rst_n_o), 0);
    rd_chk("R5 count kept at 4", 3'd6, 4);
    idle(6);
    rd_chk("R5 err flag", 3'd4, 2);
    rd_chk("R7 err cleared", 3'd4, 0);
    tick(1);
    wr(3'd3, KEY);
    chk("R5 at delta no reset", int'(wdt_rst_n_o), 1);
    rd_chk("R5 at delta reload", 3'd6, 10);
    rd_chk("R5 no flag", 3'd4, 0);
  endtask

  task automatic t_wrongkey;
    wr(3'd3, 16'h1234);
    chk("R6 no reset", int'(wdt_rst_n_o), 1);
    rd_chk("R6 count", 3'd6, 10);
    rd_chk("R6 no flag", 3'd4, 0);
    tick(7);
    wr(3'd3, 16'hC3A4);
    rd_chk("R6 in window", 3'd6, 3);
  endtask

  task automatic t_lock;
    wr(3'd5, 16'h0000);
    rd_chk("R8 locked", 3'd5, 1);
    wr(3'd1, 16'h123);
    rd_chk("R8 reload kept", 3'd1, 10);
    wr(3'd2, 16'h7FF);
    rd_chk("R8 delta kept", 3'd2, 3);
    wr(3'd0, 16'h0070);
    rd_chk("R8 ctrl split", 3'd0, 'h0002);
    wr(3'd0, 16'h0003);
    wr(3'd5, UNL);
    rd_chk("R8 unlocked", 3'd5, 0);
    wr(3'd1, 16'h123);
    rd_chk("R8 reload written", 3'd1, 'h123);
    wr(3'd2, 16'hFFF);
  endtask

  task automatic t_stop;
    wr(3'd3, KEY);
    wr(3'd0, 16'h0007);
    dbg_halt_i = 1'b1;
    tick(3);
    rd_chk("R9 dbg halt", 3'd6, 'h123);
    dbg_halt_i = 1'b0;
    tick(2);
    rd_chk("R9 dbg resume", 3'd6, 'h121);
    sleep_i = 1'b1;
    tick(2);
    rd_chk("R9 sleep runs", 3'd6, 'h11F);
    wr(3'd0, 16'h000F);
    tick(2);
    rd_chk("R9 sleep halt", 3'd6, 'h11F);
    sleep_i = 1'b0;
    tick(1);
    rd_chk("R9 wake", 3'd6, 'h11E);
    wr(3'd0, 16'h0002);
    tick(3);
    rd_chk("R9 disabled", 3'd6, 'h11E);
    wr(3'd0, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_underflow;
    t_noreset;
    t_window;
    t_wrongkey;
    t_lock;
    t_stop;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule